// File: doc/BRIEF.md
# PMBus Multi-Address Target Matcher

This block sits behind the bit-level engine of an SMBus/PMBus target. For every received address byte it decides whether the transaction is meant for this device, and through which kind of address it arrived. The byte carries the 7-bit address in bits [7:1] and the direction in bit [0] (1 = read). The block recognises three kinds of address.

- **Global addresses.** Two fixed addresses that can never be switched off.
- **Device address.** A programmable address that external address-select pin codes may partly or fully override.
- **Rail addresses.** One per channel, for two channels. A page register steers each rail-address write to one channel or to both.

One clock after the address strobe, the block reports a hit flag, the kind of match and the mask of channels the transaction addresses. A read that lands on a rail address also raises a one-cycle communication-fault pulse.

The register writes come from the command decoder through simple write strobes. A write that arrives in the same cycle as an address strobe takes effect only for later strobes.

Top module: `pmbus_addr_match`

## Requirements
- R1: After reset the outputs are low, the device address register holds `DEV_RST` (0x40 by default), the page is 0x00 and both rail address registers hold 0x80 (rail matching off).
- R2: A received address of 0x5A or 0x5B hits with kind 2'b01 and channel mask 2'b11 for both reads and writes, whatever the register contents (including device address 0x80).
- R3: When the device address register is not 0x80, a received address equal to the effective device address hits with kind 2'b10 and mask 2'b11. The value 0x80 disables device matching.
- R4: Address-select pin codes shape the effective device address. When `asel_hi[3]` is 0, `asel_hi[2:0]` replaces address bits [6:4]. When `asel_lo[4]` is 0, `asel_lo[3:0]` replaces bits [3:0]. When both are 1 ("open"), the stored register bits [6:0] alone form the address.
- R5: A page write of 0x00, 0x01 or 0xFF is stored, and any other value leaves the page unchanged. A rail address write goes to channel 0 when the page is 0x00, to channel 1 when it is 0x01, and to both channels when it is 0xFF.
- R6: A received address equal to bits [6:0] of an enabled rail register (any value other than 0x80) hits with kind 2'b11. The mask has a bit set for exactly those channels whose rail address matches, with bit n standing for channel n.
- R7: Priority is global, then device, then rail. An address that fits several kinds reports the highest-priority kind only.
- R8: A rail hit on a read raises `cml_fault` for exactly the cycle in which that result is shown. A rail hit on a write, and every non-rail result, leaves it low.
- R9: The result appears in the first cycle after the cycle in which `addr_stb` is high. In every other cycle `hit`, `hit_kind`, `ch_mask` and `cml_fault` are all 0, and a miss also reports all 0. A register write in the strobe cycle does not affect that strobe's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | Address byte valid this cycle |
| addr_byte | input | 8 | Address in [7:1], read flag in [0] |
| dev_wr | input | 1 | Write the device address register |
| dev_wdata | input | 8 | Device address register data |
| page_wr | input | 1 | Write the page register |
| page_wdata | input | 8 | Page register data |
| rail_wr | input | 1 | Write the rail address of the paged channel(s) |
| rail_wdata | input | 8 | Rail address data |
| asel_hi | input | 4 | Pin code for address bits [6:4], bit 3 = open |
| asel_lo | input | 5 | Pin code for address bits [3:0], bit 4 = open |
| hit | output | 1 | Address matched (one cycle after strobe) |
| hit_kind | output | 2 | 00 none, 01 global, 10 device, 11 rail |
| ch_mask | output | 2 | Channels addressed by the transaction |
| cml_fault | output | 1 | Pulse on a read to a rail address |

## Verification
The bench builds the block with its default parameters: device address reset value 0x40, global addresses 0x5A/0x5B and disable code 0x80. Keeping these defaults lets the directed cases place the device address and the rail addresses exactly on a global address and on each other, which exercises every step of the priority chain. The random phase draws addresses mostly from the live set of global, effective-device and rail addresses. It also toggles the pin codes between open and driven, and writes illegal page values, so that masking, overriding and the both-channel page all meet overlapping matches and rail reads.

// File: rtl/pmbus_addr_match.sv
module pmbus_addr_match #(
  parameter logic [7:0] DEV_RST  = 8'h40,
  parameter logic [6:0] GLB_A    = 7'h5A,
  parameter logic [6:0] GLB_B    = 7'h5B,
  parameter logic [7:0] OFF_CODE = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_stb,
  input  logic [7:0] addr_byte,
  input  logic       dev_wr,
  input  logic [7:0] dev_wdata,
  input  logic       page_wr,
  input  logic [7:0] page_wdata,
  input  logic       rail_wr,
  input  logic [7:0] rail_wdata,
  input  logic [3:0] asel_hi,
  input  logic [4:0] asel_lo,
  output logic       hit,
  output logic [1:0] hit_kind,
  output logic [1:0] ch_mask,
  output logic       cml_fault
);
  localparam int NCH = 2;
  localparam logic [7:0] PAGE_ALL = 8'hFF;

  logic [7:0] dev_q;
  logic [7:0] page_q;
  logic [7:0] rail_q [NCH];
  logic [NCH-1:0] rail_hit;

  wire [6:0] rx_addr  = addr_byte[7:1];
  wire       rx_read  = addr_byte[0];
  wire       page_ok  = (page_wdata == 8'h00) || (page_wdata == 8'h01) || (page_wdata == PAGE_ALL);
  wire [6:0] eff_addr = {asel_hi[3] ? dev_q[6:4] : asel_hi[2:0],
                         asel_lo[4] ? dev_q[3:0] : asel_lo[3:0]};
  wire       glb_hit  = (rx_addr == GLB_A) || (rx_addr == GLB_B);
  wire       dev_hit  = (dev_q != OFF_CODE) && (rx_addr == eff_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q  <= DEV_RST;
      page_q <= 8'h00;
    end else begin
      if (dev_wr)            dev_q  <= dev_wdata;
      if (page_wr && page_ok) page_q <= page_wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rail
    always_ff @(posedge clk) begin
      if (!rst_n)
        rail_q[c] <= OFF_CODE;
      else if (rail_wr && (page_q == 8'(c) || page_q == PAGE_ALL))
        rail_q[c] <= rail_wdata;
    end
    assign rail_hit[c] = (rail_q[c] != OFF_CODE) && (rail_q[c][6:0] == rx_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !addr_stb) begin
      hit       <= 1'b0;
      hit_kind  <= 2'b00;
      ch_mask   <= '0;
      cml_fault <= 1'b0;
    end else if (glb_hit) begin
      hit       <= 1'b1;
      hit_kind  <= 2'b01;
      ch_mask   <= '1;
      cml_fault <= 1'b0;
    end else if (dev_hit) begin
      hit       <= 1'b1;
      hit_kind  <= 2'b10;
      ch_mask   <= '1;
      cml_fault <= 1'b0;
    end else if (|rail_hit) begin
      hit       <= 1'b1;
      hit_kind  <= 2'b11;
      ch_mask   <= rail_hit;
      cml_fault <= rx_read;
    end else begin
      hit       <= 1'b0;
      hit_kind  <= 2'b00;
      ch_mask   <= '0;
      cml_fault <= 1'b0;
    end
  end
endmodule

module pmbus_addr_match_chk #(
  parameter logic [6:0] GLB_A = 7'h5A,
  parameter logic [6:0] GLB_B = 7'h5B
) (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_stb,
  input logic [7:0] addr_byte,
  input logic       hit,
  input logic [1:0] hit_kind,
  input logic [1:0] ch_mask,
  input logic       cml_fault,
  input logic [7:0] page_q
);
  // R9
  result_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(addr_stb));
  // R9
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_kind == 2'b00 && ch_mask == 2'b00 && !cml_fault));
  // R2
  global_always_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && (addr_byte[7:1] == GLB_A || addr_byte[7:1] == GLB_B))
      |=> (hit && hit_kind == 2'b01 && ch_mask == 2'b11));
  // R8
  fault_on_rail_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cml_fault |-> (hit_kind == 2'b11 && $past(addr_byte[0])));
  // R6
  rail_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_kind == 2'b11) |-> (ch_mask != 2'b00));
  // R5
  page_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q == 8'h00 || page_q == 8'h01 || page_q == 8'hFF));
endmodule

bind pmbus_addr_match pmbus_addr_match_chk #(.GLB_A(GLB_A), .GLB_B(GLB_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_byte(addr_byte),
  .hit(hit), .hit_kind(hit_kind), .ch_mask(ch_mask), .cml_fault(cml_fault),
  .page_q(page_q));

// File: tb/pmbus_addr_match_test.sv
`timescale 1ns/1ps
module pmbus_addr_match_test;
  logic clk = 0;
  logic rst_n = 0;
  logic addr_stb = 0;
  logic [7:0] addr_byte = 0;
  logic dev_wr = 0, page_wr = 0, rail_wr = 0;
  logic [7:0] dev_wdata = 0, page_wdata = 0, rail_wdata = 0;
  logic [3:0] asel_hi = 4'h8;
  logic [4:0] asel_lo = 5'h10;
  logic hit, cml_fault;
  logic [1:0] hit_kind, ch_mask;

  int vectors = 0;
  int fails = 0;

  logic [7:0] m_dev, m_page;
  logic [7:0] m_rail [2];

  always #5 clk = ~clk;

  pmbus_addr_match uut (.*);

  function automatic logic [6:0] eff_dev();
    return {asel_hi[3] ? m_dev[6:4] : asel_hi[2:0], asel_lo[4] ? m_dev[3:0] : asel_lo[3:0]};
  endfunction

  function automatic logic [5:0] expect_out(input logic stb, input logic [7:0] b);
    logic [6:0] a = b[7:1];
    logic [1:0] rm;
    if (!stb) return 6'b0;
    if (a == 7'h5A || a == 7'h5B) return {1'b1, 2'b01, 2'b11, 1'b0};
    if (m_dev != 8'h80 && a == eff_dev()) return {1'b1, 2'b10, 2'b11, 1'b0};
    for (int c = 0; c < 2; c++) rm[c] = (m_rail[c] != 8'h80) && (m_rail[c][6:0] == a);
    if (rm != 0) return {1'b1, 2'b11, rm, b[0]};
    return 6'b0;
  endfunction

  function automatic string tag_of(input logic [5:0] e);
    case (e[4:3])
      2'b01: return "R2";
      2'b10: return "R3";
      2'b11: return e[0] ? "R8" : "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic [5:0] exp, input string tag);
    logic [5:0] act = {hit, hit_kind, ch_mask, cml_fault};
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {hit,kind,mask,fault} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic stb, input logic [7:0] b,
                      input logic dw, input logic [7:0] dd,
                      input logic pw, input logic [7:0] pd,
                      input logic rw, input logic [7:0] rd, input string tag);
    logic [5:0] exp;
    addr_stb = stb; addr_byte = b;
    dev_wr = dw; dev_wdata = dd; page_wr = pw; page_wdata = pd;
    rail_wr = rw; rail_wdata = rd;
    exp = expect_out(stb, b);
    @(negedge clk);
    addr_stb = 0; dev_wr = 0; page_wr = 0; rail_wr = 0;
    check(exp, (tag == "") ? tag_of(exp) : tag);
    if (rw) for (int c = 0; c < 2; c++)
      if (m_page == 8'(c) || m_page == 8'hFF) m_rail[c] = rd;
    if (dw) m_dev = dd;
    if (pw && (pd == 8'h00 || pd == 8'h01 || pd == 8'hFF)) m_page = pd;
  endtask

  task automatic probe(input logic [6:0] a, input logic rd, input string tag);
    step(1, {a, rd}, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    m_dev = 8'h40; m_page = 8'h00; m_rail[0] = 8'h80; m_rail[1] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state: outputs low, reset device address active, rails off
    check(6'b0, "R1");
    probe(7'h40, 0, "R1");
    probe(7'h20, 0, "R1");
    // R9 no strobe -> nothing
    step(0, {7'h40, 1'b0}, 0, 0, 0, 0, 0, 0, "R9");
    // R9 same-cycle register write does not affect this strobe
    step(1, {7'h40, 1'b0}, 1, 8'h80, 0, 0, 0, 0, "R9");
    // R3 device disabled by 0x80; R2 global still answers
    probe(7'h40, 0, "R3");
    probe(7'h5A, 1, "R2");
    probe(7'h5B, 0, "R2");
    // R3 device re-enabled
    step(0, 0, 1, 8'h33, 0, 0, 0, 0, "R9");
    probe(7'h33, 1, "R3");
    // R4 pin overrides
    asel_hi = 4'h5; probe(7'h53, 0, "R4"); probe(7'h33, 0, "R4");
    asel_lo = 5'h07; probe(7'h57, 0, "R4");
    asel_hi = 4'h8; probe(7'h37, 0, "R4");
    asel_lo = 5'h10; probe(7'h33, 0, "R4");
    // R5 page routing: ch0, ch1, both; illegal page ignored
    step(0, 0, 0, 0, 0, 0, 1, 8'h21, "R9");
    probe(7'h21, 0, "R6");
    step(0, 0, 0, 0, 1, 8'h01, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 8'h22, "R9");
    probe(7'h22, 0, "R5");
    step(0, 0, 0, 0, 1, 8'h07, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 8'h24, "R9");
    probe(7'h24, 0, "R5");
    probe(7'h22, 0, "R5");
    step(0, 0, 0, 0, 1, 8'hFF, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 8'h26, "R9");
    probe(7'h26, 0, "R6");
    // R8 read to rail faults, write does not
    probe(7'h26, 1, "R8");
    probe(7'h26, 0, "R8");
    // R7 priority: device over rail, global over device
    step(0, 0, 1, 8'h26, 0, 0, 0, 0, "R9");
    probe(7'h26, 1, "R7");
    step(0, 0, 1, 8'h5A, 0, 0, 0, 0, "R9");
    probe(7'h5A, 0, "R7");
    // R6 rail disable
    step(0, 0, 0, 0, 1, 8'h00, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 8'h80, "R9");
    probe(7'h26, 1, "R6");

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] a;
      int sel = $urandom_range(0, 9);
      if ($urandom_range(0, 15) == 0) asel_hi = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) asel_lo = 5'($urandom_range(0, 31));
      case (sel)
        0: a = 7'h5A + 7'($urandom_range(0, 1));
        1, 2: a = eff_dev();
        3, 4: a = m_rail[0][6:0];
        5, 6: a = m_rail[1][6:0];
        default: a = 7'($urandom);
      endcase
      step($urandom_range(0, 3) != 0, {a, 1'($urandom)},
           $urandom_range(0, 9) == 0, ($urandom_range(0, 3) == 0) ? 8'h80 : 8'($urandom_range(0, 127)),
           $urandom_range(0, 7) == 0, ($urandom_range(0, 3) == 0) ? 8'($urandom) : (($urandom_range(0, 2) == 2) ? 8'hFF : 8'($urandom_range(0, 1))),
           $urandom_range(0, 5) == 0, ($urandom_range(0, 4) == 0) ? 8'h80 : 8'($urandom_range(0, 127)),
           "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule